// File: doc/BRIEF.md
# Configurable-Bias 8-Bit Float Encoder

This block narrows a single-precision or bfloat16 value into an 8-bit floating-point code whose exponent bias is chosen at run time. Two bit layouts are available: one trades exponent range for a third mantissa bit, the other keeps a wider exponent with two mantissa bits. No code is set aside for infinity or NaN, so every exponent value, including all ones, encodes an ordinary number, and out-of-range results saturate.

Each accepted conversion rounds either to nearest, with ties going to even, or stochastically, using a seedable 32-bit linear-feedback generator. Loading the same seed replays the same stream of rounding decisions. Results leave through a one-deep output register with a valid/ready handshake, together with four exception flags.

Top module: `f8_bias_enc`

## Requirements
- R1: Output layout 0 is code[7]=sign, code[6:3]=exponent field, code[2:0]=mantissa. Layout 1 is code[7]=sign, code[6:2]=exponent field, code[1:0]=mantissa. A field e in 1..max with mantissa m encodes (-1)^s x 2^(e-bias) x 1.m, and the 6-bit bias ranges from 0 to 63.
- R2: With in_stoch_i=0, the result is the nearest representable value. An exact tie goes to the code whose mantissa LSB is 0.
- R3: A zero exponent field encodes (-1)^s x 2^(-bias) x 0.m. A zero input gives {sign, 7'b0}. A magnitude that rounds to at least 2^(-bias) but lies below the smallest normal becomes the smallest normal code (exponent field 1, mantissa 0).
- R4: A finite result whose rounded exponent field would exceed the all-ones value gives {sign, 7'h7F} and raises out_ovf_o. An exact maximum with an all-ones exponent field is a normal result with no flag.
- R5: A NaN input gives {sign, 7'h7F} with out_inv_o set. An infinite input gives {sign, 7'h7F} with no flag.
- R6: out_unf_o is set when the input is nonzero, the result has exponent field 0, and nonzero bits were discarded. out_unf_o and out_ovf_o are never set together.
- R7: An input with zero exponent and nonzero mantissa raises out_den_o. It is taken as 2^-126 x 0.M, and a bias below 64 makes it round to zero with underflow under round-to-nearest.
- R8: With in_bf16_i=1, only in_data_i[15:0] is used: sign in bit 15, 8-bit exponent in bits 14:7, and a 7-bit mantissa that is zero-extended to 23 bits.
- R9: With in_stoch_i=1, the result rounds up exactly when the 32 discarded bits just below the result LSB, added to the generator state, carry out of 32 bits. An exact input never rounds up.
- R10: The generator state resets to 1 and advances once per accepted conversion as next = (s >> 1) ^ (s[0] ? 32'h80200003 : 0). seed_load_i loads seed_i (a zero seed loads 1) and takes priority over advancing. A conversion accepted in the load cycle uses the old state.
- R11: in_ready_o = !out_valid_o | out_ready_i. The result appears one clock after acceptance. The result and its flags hold while out_valid_o=1 and out_ready_i=0. Reset clears out_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input value present |
| in_ready_o | output | 1 | Block can take an input this cycle |
| in_data_i | input | 32 | Source value (single precision, or bfloat16 in bits 15:0) |
| in_bf16_i | input | 1 | 1 = source is bfloat16 |
| in_layout_i | input | 1 | 0 = 4-bit exponent layout, 1 = 5-bit exponent layout |
| in_bias_i | input | 6 | Unsigned exponent bias |
| in_stoch_i | input | 1 | 1 = stochastic rounding, 0 = round to nearest even |
| seed_load_i | input | 1 | Load the generator from seed_i |
| seed_i | input | 32 | Generator seed |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| out_code_o | output | 8 | 8-bit result code |
| out_inv_o | output | 1 | NaN input |
| out_den_o | output | 1 | Denormal input |
| out_ovf_o | output | 1 | Result saturated by overflow |
| out_unf_o | output | 1 | Tiny inexact result |

## Verification
The bound checker checks handshake behaviour on every cycle: back-pressure drops ready, a stalled result stays frozen, and every accepted input gives a result on the next clock. On every valid result it also checks that the flags agree with the code: overflow and NaN results carry the saturated magnitude, an underflow result has a zero exponent field in the layout that was captured with it, and a denormal input never shows up as invalid or overflow. The specific rounding choices cannot be seen from a single cycle, so the bench scenarios cover them: ties to even, the gap below the smallest normal, bias shifts, bfloat16 field placement, and the exact sequence of stochastic decisions after reset, after a seed load, and after loading a zero seed.

// File: rtl/f8_enc_pkg.sv
package f8_enc_pkg;
  localparam int IN_W     = 32;
  localparam int CODE_W   = 8;
  localparam int BIAS_W   = 6;
  localparam int RND_W    = 32;
  localparam int SIG_W    = 24;
  localparam int MAN_W    = 23;
  localparam int SRC_EW   = 8;
  localparam int XEXP_W   = 10;
  localparam int N_LAYOUT = 2;

  localparam logic [RND_W-1:0] LFSR_MASK = 32'h8020_0003;
  localparam logic [RND_W-1:0] LFSR_INIT = 32'h0000_0001;

  typedef struct packed {
    logic inv;
    logic den;
    logic ovf;
    logic unf;
  } f8_flags_t;

  typedef struct packed {
    logic                     sign;
    logic signed [XEXP_W-1:0] xexp;
    logic [SIG_W-1:0]         sig;
    logic                     is_nan;
    logic                     is_inf;
    logic                     is_zero;
    logic                     is_den;
  } f8_src_t;

  function automatic int lay_mw(int idx);
    return (idx == 0) ? 3 : 2;
  endfunction

  function automatic int lay_ew(int idx);
    return CODE_W - 1 - lay_mw(idx);
  endfunction
endpackage

// File: rtl/f8_src_unpack.sv
module f8_src_unpack
  import f8_enc_pkg::*;
(
  input  logic [IN_W-1:0] data_i,
  input  logic            bf16_i,
  output f8_src_t         src_o
);
  logic              s;
  logic [SRC_EW-1:0] ef;
  logic [MAN_W-1:0]  mf;

  always_comb begin
    if (bf16_i) begin
      s  = data_i[15];
      ef = data_i[14:7];
      mf = {data_i[6:0], 16'b0};
    end else begin
      s  = data_i[31];
      ef = data_i[30:23];
      mf = data_i[22:0];
    end
  end

  always_comb begin
    src_o.sign    = s;
    src_o.is_nan  = (ef == '1) && (mf != '0);
    src_o.is_inf  = (ef == '1) && (mf == '0);
    src_o.is_zero = (ef == '0) && (mf == '0);
    src_o.is_den  = (ef == '0) && (mf != '0);
    src_o.sig     = {(ef != '0), mf};
    // denormal sources share the minimum exponent with a zero hidden bit
    src_o.xexp    = (ef == '0) ? -10'sd126 : ($signed({2'b00, ef}) - 10'sd127);
  end
endmodule

// File: rtl/f8_lfsr.sv
module f8_lfsr #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     MASK = 32'h8020_0003,
  parameter logic [W-1:0]     INIT = 32'h1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= INIT;
    end else if (load_i) begin
      state_q <= (seed_i == '0) ? INIT : seed_i;
    end else if (adv_i) begin
      state_q <= (state_q >> 1) ^ (state_q[0] ? MASK : '0);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/f8_round.sv
module f8_round
  import f8_enc_pkg::*;
#(
  parameter int EW = 4,
  parameter int MW = 3
) (
  input  logic                     sign_i,
  input  logic signed [XEXP_W-1:0] xexp_i,
  input  logic [SIG_W-1:0]         sig_i,
  input  logic                     sat_i,
  input  logic                     zero_i,
  input  logic [BIAS_W-1:0]        bias_i,
  input  logic                     stoch_i,
  input  logic [RND_W-1:0]         rnd_i,
  output logic [CODE_W-1:0]        code_o,
  output logic                     ovf_o,
  output logic                     unf_o
);
  localparam int KW      = MW + 1;
  localparam int FIELD_W = SIG_W + RND_W;
  localparam int FW      = FIELD_W - KW;
  localparam int EMAX    = (1 << EW) - 1;
  localparam int XW      = XEXP_W + 1;
  localparam logic signed [XW-1:0] EMAX_S  = XW'(EMAX);
  localparam logic signed [XW-1:0] SH_LIM  = XW'(RND_W);

  logic signed [XW-1:0] e_tgt, e_neg, e_fin;
  logic                 is_norm, far;
  logic [5:0]           sh;
  logic [FIELD_W-1:0]   field;
  logic [KW-1:0]        kept;
  logic [FW-1:0]        frac;
  logic [RND_W-1:0]     frac_top;
  logic                 half, rest, inexact;
  logic                 rne_inc, sr_inc, inc;
  logic [KW:0]          kr;
  logic [MW-1:0]        m_fin;

  assign e_tgt   = $signed({xexp_i[XEXP_W-1], xexp_i}) + $signed({5'b0, bias_i});
  assign is_norm = e_tgt > 11'sd0;
  assign e_neg   = -e_tgt;
  assign far     = !is_norm && (e_neg > SH_LIM);
  assign sh      = (is_norm || far) ? 6'd0 : e_neg[5:0];

  // align to the result grid; bits beyond the window collapse to sticky
  assign field    = far ? '0 : ({sig_i, {RND_W{1'b0}}} >> sh);
  assign kept     = field[FIELD_W-1 -: KW];
  assign frac     = field[FW-1:0];
  assign frac_top = frac[FW-1 -: RND_W];

  assign half    = frac[FW-1];
  assign rest    = (|frac[FW-2:0]) | far;
  assign inexact = half | rest;

  assign rne_inc = half & (rest | kept[0]);
  assign sr_inc  = frac_top > ~rnd_i;   // carry of frac_top + rnd_i
  assign inc     = stoch_i ? sr_inc : rne_inc;

  assign kr = {1'b0, kept} + {{KW{1'b0}}, inc};

  always_comb begin
    if (is_norm) begin
      if (kr[KW]) begin
        e_fin = e_tgt + 11'sd1;
        m_fin = '0;
      end else begin
        e_fin = e_tgt;
        m_fin = kr[MW-1:0];
      end
    end else if (|kr[KW:MW]) begin
      e_fin = 11'sd1;
      m_fin = '0;
    end else begin
      e_fin = 11'sd0;
      m_fin = kr[MW-1:0];
    end
  end

  always_comb begin
    ovf_o = !sat_i && !zero_i && (e_fin > EMAX_S);
    unf_o = !sat_i && !zero_i && (e_fin == 11'sd0) && inexact;
    if (sat_i || ovf_o) begin
      code_o = {sign_i, {(CODE_W-1){1'b1}}};
    end else if (zero_i) begin
      code_o = {sign_i, {(CODE_W-1){1'b0}}};
    end else begin
      code_o = {sign_i, e_fin[EW-1:0], m_fin};
    end
  end
endmodule

// File: rtl/f8_bias_enc.sv
module f8_bias_enc
  import f8_enc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [IN_W-1:0]   in_data_i,
  input  logic              in_bf16_i,
  input  logic              in_layout_i,
  input  logic [BIAS_W-1:0] in_bias_i,
  input  logic              in_stoch_i,
  input  logic              seed_load_i,
  input  logic [RND_W-1:0]  seed_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [CODE_W-1:0] out_code_o,
  output logic              out_inv_o,
  output logic              out_den_o,
  output logic              out_ovf_o,
  output logic              out_unf_o
);
  f8_src_t             src;
  logic [RND_W-1:0]    rnd;
  logic                fire;
  logic [CODE_W-1:0]   lane_code [N_LAYOUT];
  logic [N_LAYOUT-1:0] lane_ovf, lane_unf;

  logic                valid_q;
  logic [CODE_W-1:0]   code_q;
  f8_flags_t           flags_q, flags_d;

  assign in_ready_o = !valid_q || out_ready_i;
  assign fire       = in_valid_i && in_ready_o;

  f8_src_unpack u_unpack (
    .data_i (in_data_i),
    .bf16_i (in_bf16_i),
    .src_o  (src)
  );

  f8_lfsr #(
    .W    (RND_W),
    .MASK (LFSR_MASK),
    .INIT (LFSR_INIT)
  ) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seed_load_i),
    .seed_i  (seed_i),
    .adv_i   (fire),
    .state_o (rnd)
  );

  for (genvar g = 0; g < N_LAYOUT; g++) begin : g_lane
    f8_round #(
      .EW (lay_ew(g)),
      .MW (lay_mw(g))
    ) u_round (
      .sign_i  (src.sign),
      .xexp_i  (src.xexp),
      .sig_i   (src.sig),
      .sat_i   (src.is_nan || src.is_inf),
      .zero_i  (src.is_zero),
      .bias_i  (in_bias_i),
      .stoch_i (in_stoch_i),
      .rnd_i   (rnd),
      .code_o  (lane_code[g]),
      .ovf_o   (lane_ovf[g]),
      .unf_o   (lane_unf[g])
    );
  end

  always_comb begin
    flags_d.inv = src.is_nan;
    flags_d.den = src.is_den;
    flags_d.ovf = lane_ovf[in_layout_i];
    flags_d.unf = lane_unf[in_layout_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      flags_q <= '0;
    end else if (fire) begin
      valid_q <= 1'b1;
      code_q  <= lane_code[in_layout_i];
      flags_q <= flags_d;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign out_code_o  = code_q;
  assign out_inv_o   = flags_q.inv;
  assign out_den_o   = flags_q.den;
  assign out_ovf_o   = flags_q.ovf;
  assign out_unf_o   = flags_q.unf;
endmodule

// File: rtl/f8_bias_enc_chk.sv
module f8_bias_enc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic       in_layout_i,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_code_o,
  input logic       out_inv_o,
  input logic       out_den_o,
  input logic       out_ovf_o,
  input logic       out_unf_o
);
  logic lay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       lay_q <= 1'b0;
    else if (in_valid_i && in_ready_o) lay_q <= in_layout_i;
  end

  AST_BP_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R11
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_code_o)); // R11
  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R11
  AST_OVF_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ovf_o |-> out_code_o[6:0] == 7'h7f); // R4
  AST_NAN_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_inv_o |-> out_code_o[6:0] == 7'h7f); // R5
  AST_UNF_EXP_L0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_unf_o && !lay_q |-> out_code_o[6:3] == 4'h0); // R6
  AST_UNF_EXP_L1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_unf_o && lay_q |-> out_code_o[6:2] == 5'h00); // R6
  AST_NO_OVF_UNF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(out_ovf_o && out_unf_o)); // R6
  AST_DEN_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_den_o |-> !out_inv_o && !out_ovf_o); // R7
endmodule

bind f8_bias_enc f8_bias_enc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_layout_i (in_layout_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_code_o  (out_code_o),
  .out_inv_o   (out_inv_o),
  .out_den_o   (out_den_o),
  .out_ovf_o   (out_ovf_o),
  .out_unf_o   (out_unf_o)
);

// File: tb/tb_f8_bias_enc.sv
module tb_f8_bias_enc;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 29;

  // flags nibble: {inv, den, ovf, unf}
  typedef struct packed {
    logic [31:0] data;
    logic        bf16;
    logic        lay;
    logic [5:0]  bias;
    logic [7:0]  code;
    logic [3:0]  fl;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{32'h3F800000, 1'b0, 1'b0, 6'd7,  8'h38, 4'h0, 4'd1}, // R1 1.0
    '{32'hBF800000, 1'b0, 1'b1, 6'd15, 8'hBC, 4'h0, 4'd1}, // R1 -1.0 layout 1
    '{32'h3F800000, 1'b0, 1'b0, 6'd3,  8'h18, 4'h0, 4'd1}, // R1 bias shift
    '{32'h2B800000, 1'b0, 1'b1, 6'd63, 8'h5C, 4'h0, 4'd1}, // R1 2^-40, bias 63
    '{32'h3FE00000, 1'b0, 1'b1, 6'd15, 8'h3F, 4'h0, 4'd1}, // R1 1.75
    '{32'h3F880000, 1'b0, 1'b0, 6'd7,  8'h38, 4'h0, 4'd2}, // R2 tie to even, down
    '{32'h3F980000, 1'b0, 1'b0, 6'd7,  8'h3A, 4'h0, 4'd2}, // R2 tie to even, up
    '{32'h3F8C0000, 1'b0, 1'b0, 6'd7,  8'h39, 4'h0, 4'd2}, // R2 above half
    '{32'h3F900000, 1'b0, 1'b1, 6'd15, 8'h3C, 4'h0, 4'd2}, // R2 tie down layout 1
    '{32'h3FB00000, 1'b0, 1'b1, 6'd15, 8'h3E, 4'h0, 4'd2}, // R2 tie up layout 1
    '{32'h3B800000, 1'b0, 1'b0, 6'd7,  8'h04, 4'h0, 4'd3}, // R3 exact denormal
    '{32'h3C000000, 1'b0, 1'b0, 6'd7,  8'h08, 4'h0, 4'd3}, // R3 gap -> min normal
    '{32'h3BF80000, 1'b0, 1'b0, 6'd7,  8'h08, 4'h0, 4'd3}, // R3 denormal rounds up
    '{32'h80000000, 1'b0, 1'b1, 6'd20, 8'h80, 4'h0, 4'd3}, // R3 signed zero
    '{32'h47780000, 1'b0, 1'b0, 6'd0,  8'h7F, 4'h2, 4'd4}, // R4 rounding overflow
    '{32'h47700000, 1'b0, 1'b0, 6'd0,  8'h7F, 4'h0, 4'd4}, // R4 exact max
    '{32'hD3800000, 1'b0, 1'b1, 6'd0,  8'hFF, 4'h2, 4'd4}, // R4 negative overflow
    '{32'h7FC00000, 1'b0, 1'b0, 6'd9,  8'h7F, 4'h8, 4'd5}, // R5 NaN
    '{32'hFFC00000, 1'b0, 1'b1, 6'd9,  8'hFF, 4'h8, 4'd5}, // R5 negative NaN
    '{32'h7F800000, 1'b0, 1'b1, 6'd9,  8'h7F, 4'h0, 4'd5}, // R5 +inf
    '{32'hFF800000, 1'b0, 1'b0, 6'd9,  8'hFF, 4'h0, 4'd5}, // R5 -inf
    '{32'h3B880000, 1'b0, 1'b0, 6'd7,  8'h04, 4'h1, 4'd6}, // R6 inexact denormal
    '{32'h3A800000, 1'b0, 1'b1, 6'd0,  8'h00, 4'h1, 4'd6}, // R6 flush to zero
    '{32'h00000001, 1'b0, 1'b0, 6'd0,  8'h00, 4'h5, 4'd7}, // R7 denormal input
    '{32'h80400000, 1'b0, 1'b1, 6'd63, 8'h80, 4'h5, 4'd7}, // R7 negative denormal
    '{32'h00003F80, 1'b1, 1'b0, 6'd7,  8'h38, 4'h0, 4'd8}, // R8 bf16 1.0
    '{32'hABCD3FC0, 1'b1, 1'b0, 6'd7,  8'h3C, 4'h0, 4'd8}, // R8 upper half ignored
    '{32'h12347FC1, 1'b1, 1'b1, 6'd0,  8'h7F, 4'h8, 4'd8}, // R8 bf16 NaN
    '{32'h0000C000, 1'b1, 1'b1, 6'd15, 8'hC0, 4'h0, 4'd8}  // R8 bf16 -2.0
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic        in_bf16_i = 1'b0;
  logic        in_layout_i = 1'b0;
  logic [5:0]  in_bias_i = '0;
  logic        in_stoch_i = 1'b0;
  logic        seed_load_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [7:0]  out_code_o;
  logic        out_inv_o, out_den_o, out_ovf_o, out_unf_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  f8_bias_enc dut (.*);

  function automatic logic [31:0] lfsr_next(logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_seed(logic [31:0] s);
    @(negedge clk_i);
    seed_load_i = 1'b1;
    seed_i      = s;
    @(negedge clk_i);
    seed_load_i = 1'b0;
  endtask

  task automatic convert(logic [31:0] d, logic bf, logic lay, logic [5:0] b, logic st,
                         output logic [7:0] code, output logic [3:0] fl, output logic vld);
    @(negedge clk_i);
    in_valid_i  = 1'b1;
    in_data_i   = d;
    in_bf16_i   = bf;
    in_layout_i = lay;
    in_bias_i   = b;
    in_stoch_i  = st;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    code = out_code_o;
    fl   = {out_inv_o, out_den_o, out_ovf_o, out_unf_o};
    vld  = out_valid_o;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  code;
    logic [3:0]  fl;
    logic        vld;
    logic [31:0] st;
    logic [7:0]  run1 [6];

    // reset state, R11
    repeat (2) @(negedge clk_i);
    chk("R11 reset valid", 32'(out_valid_o), 32'd0);
    chk("R11 reset ready", 32'(in_ready_o), 32'd1);
    rst_ni = 1'b1;

    // R10 generator starts at 1: bit31 of 1 then of 0x80200003
    convert(32'h3F880000, 1'b0, 1'b0, 6'd7, 1'b1, code, fl, vld);
    chk("R10 reset state draw 0", 32'(code), 32'h38);
    convert(32'h3F880000, 1'b0, 1'b0, 6'd7, 1'b1, code, fl, vld);
    chk("R10 reset state draw 1", 32'(code), 32'h39);

    for (int i = 0; i < N_VEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      convert(VECS[i].data, VECS[i].bf16, VECS[i].lay, VECS[i].bias, 1'b0, code, fl, vld);
      chk({tag, " valid"}, 32'(vld), 32'd1);
      chk({tag, " code"}, 32'(code), 32'(VECS[i].code));
      chk({tag, " flags"}, 32'(fl), 32'(VECS[i].fl));
    end

    // R11 back-pressure
    @(negedge clk_i);
    out_ready_i = 1'b0;
    in_valid_i  = 1'b1;
    in_data_i   = 32'h3F800000;
    in_bf16_i   = 1'b0;
    in_layout_i = 1'b0;
    in_bias_i   = 6'd7;
    in_stoch_i  = 1'b0;
    @(negedge clk_i);
    chk("R11 stall valid", 32'(out_valid_o), 32'd1);
    chk("R11 stall ready", 32'(in_ready_o), 32'd0);
    chk("R11 stall code", 32'(out_code_o), 32'h38);
    in_data_i = 32'h3F8C0000;
    @(negedge clk_i);
    chk("R11 held code", 32'(out_code_o), 32'h38);
    out_ready_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R11 released code", 32'(out_code_o), 32'h39);
    @(negedge clk_i);
    chk("R11 drained valid", 32'(out_valid_o), 32'd0);

    // R9 stochastic sequence after a seed load; half-ulp fraction rounds up iff rnd[31]
    load_seed(32'hACE1_2345);
    st = 32'hACE1_2345;
    for (int i = 0; i < 6; i++) begin
      convert(32'h3F880000, 1'b0, 1'b0, 6'd7, 1'b1, code, fl, vld);
      run1[i] = code;
      chk("R9 stochastic code", 32'(code), 32'(8'h38 | {7'b0, st[31]}));
      chk("R9 stochastic flags", 32'(fl), 32'd0);
      st = lfsr_next(st);
    end
    // R9 exact input never rounds up
    convert(32'h3F800000, 1'b0, 1'b0, 6'd7, 1'b1, code, fl, vld);
    chk("R9 exact stochastic", 32'(code), 32'h38);

    // R10 same seed replays the same decisions
    load_seed(32'hACE1_2345);
    for (int i = 0; i < 6; i++) begin
      convert(32'h3F880000, 1'b0, 1'b0, 6'd7, 1'b1, code, fl, vld);
      chk("R10 replay", 32'(code), 32'(run1[i]));
    end

    // R10 zero seed loads 1
    load_seed(32'h0);
    convert(32'h3F880000, 1'b0, 1'b0, 6'd7, 1'b1, code, fl, vld);
    chk("R10 zero seed draw 0", 32'(code), 32'h38);
    convert(32'h3F880000, 1'b0, 1'b0, 6'd7, 1'b1, code, fl, vld);
    chk("R10 zero seed draw 1", 32'(code), 32'h39);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule